// File: doc/BRIEF.md
# SAR ADC Serial Port Model

This block is a cycle-level model of the digital serial port of a 14-bit successive-approximation converter. The port flags its own busy state on the data output. A host raises CNV to start a conversion. A fixed number of system clock cycles later, the block raises a one-cycle end-of-conversion event. That event is the only moment at which two things happen: a configuration word that was shifted in on DIN is committed, and a new result is loaded for readout on SDO. The result value is taken from a 14-bit input, so a test environment can supply any value it likes.

The serial signals CNV, SCK and DIN are sampled by the system clock and edge-detected. DIN is taken on SCK rising edges. SDO changes on SCK falling edges, most significant bit first. The output has an explicit drive enable; low on that enable stands for high impedance. Depending on a readback flag held in the committed configuration, a readout is 14 bits long or 28 bits long, and the line is released on the edge that follows the last bit. The busy indication is built from the level of CNV and from whatever state SDO was left in by the previous readout.

Top module: `sar_serial_port`

## Requirements
- R1: The end-of-conversion pulse `eoc` is high for exactly one clock cycle. It goes high CONV_CYCLES clock edges after the edge at which a rising CNV is first registered. A rising CNV that arrives while a conversion is running is ignored.
- R2: DIN is captured on SCK rising edges, most significant bit first. Only the first 14 bits after the previous end of conversion form the pending configuration word; any further bits in the same interval are ignored.
- R3: A configuration word is committed only at end of conversion, and only if all 14 bits have arrived. A partial word is dropped and the previous configuration stays in force.
- R4: A word that is pending at the first end of conversion after reset is never committed, so a configuration can take effect no earlier than the second end of conversion.
- R5: Each end of conversion loads `result_i`. After that, SCK falling edge k (k = 1..14) drives result bit 14-k on SDO with the output enabled.
- R6: With readback off, the 15th falling edge after end of conversion releases SDO (`sdo_oe` = 0). Every later edge leaves it released until the next end of conversion.
- R7: When bit 13 of the committed configuration is 1, falling edges 15..28 drive that configuration, most significant bit first. The 29th edge releases SDO. The commit made at an end of conversion already applies to the readout loaded at that same end of conversion.
- R8: While a conversion runs with CNV low, an SDO that is released, or that is still driving a 1, is driven low. At end of conversion with CNV still low, that armed line is driven high.
- R9: If an interrupted readout leaves SDO driving a 0, the busy indication is suppressed. SDO stays driven low through the conversion and through end of conversion.
- R10: If CNV is high at end of conversion, SDO is released at that point.
- R11: After reset, `eoc` is low, SDO is released, and the committed configuration is all zeros, which means readback is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv | input | 1 | Conversion start strobe; its level at end of conversion selects the busy indication |
| sck | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial configuration data |
| result_i | input | W | Conversion result to be loaded at end of conversion |
| sdo | output | 1 | Serial data / busy indication |
| sdo_oe | output | 1 | Drive enable for sdo; 0 means high impedance |
| eoc | output | 1 | One-cycle end-of-conversion event |

## Verification
The hardest case to reach from the ports is a readout that was deliberately stopped partway through, with SDO still driving either a 0 or a 1, followed by a new conversion. That same stopped readout also leaves a partial configuration word pending. The stimulus reaches this state by choosing result values whose bit at the stop position is known, then issuing only a few SCK pulses before raising CNV. This exercises the suppressed busy case, the armed busy case and the dropped partial word. A short CNV pulse in the middle of each conversion checks that restarts are ignored. After the directed cases, random result values, configuration words and trailing extra edges run back to back.

// File: rtl/sarport_pkg.sv
// Shared constants for the SAR serial port model.
// Assumes: nothing; holds default widths and timing only.
package sarport_pkg;
    localparam int unsigned SAR_W        = 14;  // result and configuration width
    localparam int unsigned SAR_CONV_DEF = 40;  // default conversion time in clk cycles
endpackage

// File: rtl/sarport_edge.sv
// Edge detector for a slow serial line sampled by the system clock.
// Assumes: the line is already synchronous to clk and is low while in reset.
module sarport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    // Hold the previous sample of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/sarport_conv.sv
// Conversion timer: a rising CNV starts a count of CONV_CYCLES clocks that
// ends in a one-cycle end-of-conversion event.
// Assumes: CONV_CYCLES >= 2; CNV rises during a conversion are ignored.
module sarport_conv #(
    parameter int unsigned CONV_CYCLES = sarport_pkg::SAR_CONV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv,
    output logic fire,
    output logic active,
    output logic eoc
);
    localparam int unsigned CW = $clog2(CONV_CYCLES + 1);

    logic          cnv_q;
    logic [CW-1:0] cnt;
    logic          start;

    assign start = cnv & ~cnv_q;
    assign fire  = active && (cnt == CW'(CONV_CYCLES - 1));

    // Track CNV level, run the conversion counter and register the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_q  <= 1'b0;
            active <= 1'b0;
            cnt    <= '0;
            eoc    <= 1'b0;
        end else begin
            cnv_q <= cnv;
            eoc   <= fire;
            if (fire) begin
                active <= 1'b0;
            end else if (active) begin
                cnt <= cnt + CW'(1);
            end else if (start) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end
    end

    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc); // R1
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fire) |=> active); // R1
endmodule

// File: rtl/sarport_cfg.sv
// Configuration shifter: takes DIN on SCK rises into a pending word and
// commits it at end of conversion when complete.
// Assumes: writes before and at the first end of conversion after reset are dropped.
module sarport_cfg #(
    parameter int unsigned W      = sarport_pkg::SAR_W,
    parameter int unsigned RB_BIT = W - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck_rise,
    input  logic         din,
    input  logic         fire,
    output logic [W-1:0] cfg_eff,
    output logic         rb_eff
);
    localparam int unsigned NB = $clog2(W + 1);

    logic [W-1:0]  pend;
    logic [W-1:0]  cfg_q;
    logic [NB-1:0] nbits;
    logic          seen;
    logic          full;
    logic          take;

    assign full    = (nbits == NB'(W));
    assign take    = fire && full && seen;
    assign cfg_eff = take ? pend : cfg_q;
    assign rb_eff  = cfg_eff[RB_BIT];

    // Shift pending bits, commit complete words at end of conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            cfg_q <= '0;
            nbits <= '0;
            seen  <= 1'b0;
        end else if (fire) begin
            cfg_q <= cfg_eff;
            nbits <= '0;
            seen  <= 1'b1;
        end else if (sck_rise && !full) begin
            pend  <= {pend[W-2:0], din};
            nbits <= nbits + NB'(1);
        end
    end

    AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cfg_q)); // R3
    AST_FIRST_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !seen) |=> $stable(cfg_q)); // R4
endmodule

// File: rtl/sarport_sdo.sv
// Output shifter and busy indication: loads result (plus configuration when
// readback is on) at end of conversion and steps it out on SCK falls.
// Assumes: SCK falls take priority over busy arming in the same cycle.
module sarport_sdo #(
    parameter int unsigned W = sarport_pkg::SAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic         cnv,
    input  logic         conv_active,
    input  logic         sck_fall,
    input  logic [W-1:0] result_i,
    input  logic [W-1:0] cfg_eff,
    input  logic         rb_eff,
    output logic         sdo,
    output logic         sdo_oe
);
    localparam int unsigned TOT = 2 * W;
    localparam int unsigned CW  = $clog2(TOT + 2);

    logic [TOT-1:0] word;
    logic [CW-1:0]  fcnt;
    logic [CW-1:0]  nb;
    logic [CW-1:0]  fnext;
    logic [CW-1:0]  idx;
    logic           rd;
    logic           armed;

    assign fnext = fcnt + CW'(1);
    assign idx   = CW'(TOT) - fnext;

    // Load at end of conversion, shift on falls, arm busy while converting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= '0;
            fcnt   <= '0;
            nb     <= '0;
            rd     <= 1'b0;
            armed  <= 1'b0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (fire) begin
            word  <= {result_i, (rb_eff ? cfg_eff : {W{1'b0}})};
            nb    <= rb_eff ? CW'(TOT) : CW'(W);
            fcnt  <= '0;
            rd    <= 1'b1;
            armed <= 1'b0;
            if (cnv) begin
                sdo_oe <= 1'b0;
            end else if (armed) begin
                sdo_oe <= 1'b1;
                sdo    <= 1'b1;
            end
        end else if (sck_fall && rd) begin
            fcnt <= fnext;
            if (fnext > nb) begin
                sdo_oe <= 1'b0;
                rd     <= 1'b0;
            end else begin
                sdo_oe <= 1'b1;
                sdo    <= word[idx];
            end
        end else if (conv_active && !cnv && !armed && !sck_fall && (!sdo_oe || sdo)) begin
            armed  <= 1'b1;
            rd     <= 1'b0;
            sdo_oe <= 1'b1;
            sdo    <= 1'b0;
        end
    end

    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && rd && !fire && (fcnt == nb)) |=> !sdo_oe); // R6
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cnv && armed) |=> (sdo_oe && sdo)); // R8
    AST_CNV_HIGH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cnv) |=> !sdo_oe); // R10
    AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && !fire && !sck_fall && sdo_oe && !sdo) |=> (sdo_oe && !sdo)); // R9
endmodule

// File: rtl/sar_serial_port.sv
// Top of the SAR serial port model: conversion timer, configuration shifter
// and output shifter around one sampled serial clock.
// Assumes: cnv, sck and din are synchronous to clk; sck idles low.
module sar_serial_port #(
    parameter int unsigned W           = sarport_pkg::SAR_W,
    parameter int unsigned CONV_CYCLES = sarport_pkg::SAR_CONV_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnv,
    input  logic         sck,
    input  logic         din,
    input  logic [W-1:0] result_i,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         eoc
);
    logic         sck_rise;
    logic         sck_fall;
    logic         fire;
    logic         conv_active;
    logic [W-1:0] cfg_eff;
    logic         rb_eff;

    sarport_edge u_sck_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sck),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    sarport_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .cnv   (cnv),
        .fire  (fire),
        .active(conv_active),
        .eoc   (eoc)
    );

    sarport_cfg #(.W(W), .RB_BIT(W - 1)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_rise(sck_rise),
        .din     (din),
        .fire    (fire),
        .cfg_eff (cfg_eff),
        .rb_eff  (rb_eff)
    );

    sarport_sdo #(.W(W)) u_sdo (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .cnv        (cnv),
        .conv_active(conv_active),
        .sck_fall   (sck_fall),
        .result_i   (result_i),
        .cfg_eff    (cfg_eff),
        .rb_eff     (rb_eff),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );
endmodule

// File: tb/sar_serial_port_bench.sv
// Self-checking bench: directed corner cases then seeded random traffic.
module sar_serial_port_bench;
    localparam int W    = 14;
    localparam int CONV = 40;
    localparam int TOT  = 2 * W;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv   = 1'b0;
    logic         sck   = 1'b0;
    logic         din   = 1'b0;
    logic [W-1:0] res   = '0;
    wire          sdo;
    wire          sdo_oe;
    wire          eoc;

    always #5 clk = ~clk;

    sar_serial_port #(.W(W), .CONV_CYCLES(CONV)) u_sar_serial_port (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .din(din),
        .result_i(res), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc)
    );

    int nchk  = 0;
    int nfail = 0;

    // Reference model state
    logic [W-1:0]   m_cfg   = '0;
    logic [W-1:0]   m_pend  = '0;
    int             m_wbits = 0;
    bit             m_seen  = 0;
    logic [TOT-1:0] m_word  = '0;
    int             m_nb    = 0;
    int             m_k     = 0;
    bit             m_rd    = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic line_is(input logic eo, input logic ev, input string tag);
        chk(sdo_oe === eo, tag, int'(sdo_oe), int'(eo));
        if (eo) chk(sdo === ev, tag, int'(sdo), int'(ev));
    endtask

    function automatic logic exp_bit(input logic [TOT-1:0] w, input int k);
        return w[TOT-k];
    endfunction

    // One SCK pulse with DIN = d, then check SDO after the falling edge.
    task automatic pulse(input logic d);
        din = d;
        sck = 1'b1;
        if (m_wbits < W) begin
            m_pend = {m_pend[W-2:0], d};
            m_wbits++;
        end
        @(negedge clk);
        sck = 1'b0;
        @(negedge clk);
        if (m_rd) begin
            m_k++;
            if (m_k > m_nb) begin
                m_rd = 0;
                line_is(1'b0, 1'b0, "R6 release");
            end else if (m_k > W) begin
                line_is(1'b1, exp_bit(m_word, m_k), "R7 cfg bit");
            end else begin
                line_is(1'b1, exp_bit(m_word, m_k), "R5 data bit");
            end
        end else begin
            line_is(1'b0, 1'b0, "R6 stays released");
        end
    endtask

    // n pulses writing cfgw MSB first, ones after the 14th (must be ignored, R2).
    task automatic xfer(input int n, input logic [W-1:0] cfgw);
        for (int i = 0; i < n; i++) pulse(i < W ? cfgw[W-1-i] : 1'b1);
    endtask

    // mode 0: CNV low during conversion; mode 1: CNV high until after eoc.
    task automatic do_conv(input int mode, input logic mid_oe, input logic mid_v,
                           input logic e_oe, input logic e_v, input string tag);
        int n = 0;
        bit rb;
        cnv = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (mode == 0 && n == 2)  cnv = 1'b0;
            if (mode == 0 && n == 15) cnv = 1'b1;  // R1 restart ignored
            if (mode == 0 && n == 16) cnv = 1'b0;
            if (n == 10) line_is(mid_oe, mid_v, tag);
        end while (eoc !== 1'b1 && n < CONV + 10);
        chk(n == CONV + 1, "R1 eoc timing", n, CONV + 1);
        if (m_seen && m_wbits == W) m_cfg = m_pend;
        m_seen  = 1;
        m_wbits = 0;
        rb      = m_cfg[W-1];
        m_word  = {res, (rb ? m_cfg : {W{1'b0}})};
        m_nb    = rb ? TOT : W;
        m_k     = 0;
        m_rd    = 1;
        line_is(e_oe, e_v, tag);
        @(negedge clk);
        chk(eoc === 1'b0, "R1 eoc single cycle", int'(eoc), 0);
        if (mode == 1) cnv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sdo_oe === 1'b0, "R11 reset release", int'(sdo_oe), 0);
        chk(eoc === 1'b0, "R11 reset eoc", int'(eoc), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: full word before the first conversion must not commit.
        xfer(14, 14'h3123);
        res = 14'h2A5C;
        do_conv(0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 busy from released line");
        xfer(18, 14'h2C35);
        chk(m_nb == W && sdo_oe === 1'b0, "R4 first eoc no commit", int'(sdo_oe), 0);

        // R7: committed readback; stop after 5 edges on a low bit (R9), partial cfg (R3).
        res = 14'h3C00;
        do_conv(0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 busy");
        xfer(5, 14'h0000);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R9 held low bit", int'(sdo), 0);

        res = 14'h0A5F;
        do_conv(0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 busy suppressed");
        chk(m_nb == TOT, "R3 partial word dropped", m_nb, TOT);
        xfer(29, 14'h0ABC);

        // Readback off now; stop on a high bit to test arming from a driven 1.
        res = 14'h0400;
        do_conv(0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 busy");
        xfer(4, 14'h3FFF);
        chk(sdo_oe === 1'b1 && sdo === 1'b1, "R8 held high bit", int'(sdo), 1);

        res = 14'h1234;
        do_conv(0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 high bit armed");
        xfer(15, 14'h0001);

        // R10: CNV high across end of conversion.
        res = 14'h2222;
        do_conv(1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 cnv high release");
        xfer(15, 14'h2001);

        // Seeded random traffic.
        for (int it = 0; it < 30; it++) begin
            logic [W-1:0] c;
            res = W'($urandom);
            c   = W'($urandom);
            do_conv(0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 random busy");
            xfer(m_nb + 1 + int'($urandom_range(0, 2)), c);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule